// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block steers a partial-scan chain through one complete test session. On a start request it first shifts a check pattern through the scan register. For each stored test vector it then shifts the scan flip-flop state in and applies one capture clock in normal mode, with that vector's primary-input word on its output. After the last vector it shifts out the final captured state. The vectors come from a small parameterized read-only store.

The block drives the test-control (TC) level, separate clock enables for the scan and non-scan flip-flops, the serial scan-in bit and the primary-input word. A running clock tally counts the test clocks spent. A done flag rises when the tally reaches the session length, (N_VEC + 2)·N_SFF + N_VEC + 4. The serial output has no back-pressure: every test clock consumes exactly one bit, so the chain must accept one bit per clock while busy.

Top module: `partial_scan_seq`

## Requirements
- R1: After reset the block is idle: busy, done, tc, scan_clk_en, func_clk_en, scan_data and pi_vec are all 0, and clk_count is 0.
- R2: A start seen high at a clock edge while idle or done begins a session, so busy is 1 and clk_count is 0 in the next cycle. A start seen while busy is ignored and does not alter the running session.
- R3: The session opens with a check phase of N_SFF+4 clocks. In check clock k (from 0) scan_data equals bit 1 of k, which gives the repeating sequence 0,0,1,1.
- R4: Before each vector, N_SFF scan-in clocks send that vector's scan word, most significant bit first.
- R5: Each vector is applied in exactly one clock with tc=0 and both scan_clk_en and func_clk_en at 1. pi_vec carries that vector's primary-input word in this clock only and is 0 in every other cycle.
- R6: In every shift clock (check, scan-in, scan-out) tc=1, scan_clk_en=1 and func_clk_en=0, so the non-scan flip-flops hold.
- R7: After the last vector, a scan-out phase of N_SFF clocks runs with scan_data=0. The session then ends.
- R8: clk_count rises by one for each busy cycle. done is 1 and busy is 0 once clk_count equals (N_VEC+2)·N_SFF+N_VEC+4. done and clk_count then hold until the next start.
- R9: A start given while done runs a new, identical session from a cleared tally.
- R10: Vector v takes its scan word from SCAN_WORDS[v·N_SFF +: N_SFF] and its input word from PI_WORDS[v·PI_W +: PI_W]. Vectors are applied in order 0 to N_VEC-1. The defaults give scan words 4'hC, 4'h5, 4'hA and input words 4'h6, 4'h9, 4'h3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Session request, sampled each clock |
| tc | output | 1 | Test control: 1 for shift clocks, 0 for capture |
| scan_clk_en | output | 1 | Clock enable for scan flip-flops |
| func_clk_en | output | 1 | Clock enable for non-scan flip-flops |
| scan_data | output | 1 | Serial bit into the scan chain |
| pi_vec | output | PI_W | Primary-input word during capture |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished, tally at full length |
| clk_count | output | CNT_W | Test clocks spent in the current or last session |

## Verification
The assertions assume that start is a clean synchronous level with no unknown value after reset. They also assume that at least one scan flip-flop and one vector are configured, since the check that a capture clock is followed by a shift clock depends on both. The bench changes start only on falling clock edges and holds rst_n low for several cycles. It raises start once during a running session so that the ignore rule of R2 is exercised without breaking those assumptions.

// File: rtl/ps_seq_pkg.sv
package ps_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_FLUSH     = 3'd1,
    PH_SHIFT_IN  = 3'd2,
    PH_APPLY     = 3'd3,
    PH_SHIFT_OUT = 3'd4,
    PH_DONE      = 3'd5
  } phase_e;

  function automatic int session_len(int n_sff, int n_vec);
    return (n_vec + 2) * n_sff + n_vec + 4;
  endfunction
endpackage

// File: rtl/ps_vec_rom.sv
module ps_vec_rom #(
  parameter int N_SFF = 4,
  parameter int N_VEC = 3,
  parameter int PI_W  = 4,
  parameter int VI_W  = 2,
  parameter logic [N_VEC*N_SFF-1:0] SCAN_WORDS = '0,
  parameter logic [N_VEC*PI_W-1:0]  PI_WORDS   = '0
) (
  input  logic [VI_W-1:0]  addr,
  output logic [N_SFF-1:0] scan_word,
  output logic [PI_W-1:0]  pi_word
);
  localparam int DEPTH = 1 << VI_W;

  logic [N_SFF-1:0] scan_mem [DEPTH];
  logic [PI_W-1:0]  pi_mem   [DEPTH];

  for (genvar v = 0; v < DEPTH; v++) begin : g_entry
    if (v < N_VEC) begin : g_used
      assign scan_mem[v] = SCAN_WORDS[v*N_SFF +: N_SFF];
      assign pi_mem[v]   = PI_WORDS[v*PI_W +: PI_W];
    end else begin : g_pad
      assign scan_mem[v] = '0;
      assign pi_mem[v]   = '0;
    end
  end

  assign scan_word = scan_mem[addr];
  assign pi_word   = pi_mem[addr];
endmodule

// File: rtl/ps_phase_fsm.sv
module ps_phase_fsm
  import ps_seq_pkg::*;
#(
  parameter int N_SFF = 4,
  parameter int N_VEC = 3,
  parameter int BC_W  = 4,
  parameter int VI_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output phase_e          phase,
  output logic [BC_W-1:0] bit_cnt,
  output logic [VI_W-1:0] vec_idx,
  output logic            launch
);
  localparam logic [BC_W-1:0] FLUSH_LAST = BC_W'(N_SFF + 3);
  localparam logic [BC_W-1:0] SHIFT_LAST = BC_W'(N_SFF - 1);
  localparam logic [VI_W-1:0] VEC_LAST   = VI_W'(N_VEC - 1);

  assign launch = start && (phase == PH_IDLE || phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      vec_idx <= '0;
    end else begin
      unique case (phase)
        PH_IDLE, PH_DONE: begin
          if (launch) begin
            phase   <= PH_FLUSH;
            bit_cnt <= '0;
            vec_idx <= '0;
          end
        end
        PH_FLUSH: begin
          if (bit_cnt == FLUSH_LAST) begin
            phase   <= PH_SHIFT_IN;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + BC_W'(1);
          end
        end
        PH_SHIFT_IN: begin
          if (bit_cnt == SHIFT_LAST) begin
            phase   <= PH_APPLY;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + BC_W'(1);
          end
        end
        PH_APPLY: begin
          bit_cnt <= '0;
          if (vec_idx == VEC_LAST) begin
            phase <= PH_SHIFT_OUT;
          end else begin
            phase   <= PH_SHIFT_IN;
            vec_idx <= vec_idx + VI_W'(1);
          end
        end
        PH_SHIFT_OUT: begin
          if (bit_cnt == SHIFT_LAST) begin
            phase   <= PH_DONE;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + BC_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps_clock_tally.sv
module ps_clock_tally #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/partial_scan_seq.sv
module partial_scan_seq
  import ps_seq_pkg::*;
#(
  parameter int N_SFF = 4,
  parameter int N_VEC = 3,
  parameter int PI_W  = 4,
  parameter logic [N_VEC*N_SFF-1:0] SCAN_WORDS = 12'hA5C,
  parameter logic [N_VEC*PI_W-1:0]  PI_WORDS   = 12'h396,
  parameter int CNT_W = $clog2(session_len(N_SFF, N_VEC) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             tc,
  output logic             scan_clk_en,
  output logic             func_clk_en,
  output logic             scan_data,
  output logic [PI_W-1:0]  pi_vec,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] clk_count
);
  localparam int BC_W = $clog2(N_SFF + 4) + 1;
  localparam int VI_W = (N_VEC > 1) ? $clog2(N_VEC) : 1;

  phase_e           phase;
  logic [BC_W-1:0]  bit_cnt;
  logic [VI_W-1:0]  vec_idx;
  logic             launch;
  logic [N_SFF-1:0] scan_word;
  logic [PI_W-1:0]  pi_word;
  logic             word_bit;

  ps_phase_fsm #(.N_SFF(N_SFF), .N_VEC(N_VEC), .BC_W(BC_W), .VI_W(VI_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phase(phase), .bit_cnt(bit_cnt), .vec_idx(vec_idx), .launch(launch)
  );

  ps_vec_rom #(
    .N_SFF(N_SFF), .N_VEC(N_VEC), .PI_W(PI_W), .VI_W(VI_W),
    .SCAN_WORDS(SCAN_WORDS), .PI_WORDS(PI_WORDS)
  ) u_rom (
    .addr(vec_idx), .scan_word(scan_word), .pi_word(pi_word)
  );

  ps_clock_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(launch), .inc(busy), .count(clk_count)
  );

  // MSB-first bit select driven by the shift position
  always_comb begin
    word_bit = 1'b0;
    for (int i = 0; i < N_SFF; i++) begin
      if (bit_cnt == BC_W'(N_SFF - 1 - i)) word_bit = scan_word[i];
    end
  end

  always_comb begin
    busy        = (phase == PH_FLUSH) || (phase == PH_SHIFT_IN) ||
                  (phase == PH_APPLY) || (phase == PH_SHIFT_OUT);
    done        = (phase == PH_DONE);
    tc          = busy && (phase != PH_APPLY);
    scan_clk_en = busy;
    func_clk_en = (phase == PH_APPLY);
    pi_vec      = (phase == PH_APPLY) ? pi_word : '0;
    unique case (phase)
      PH_FLUSH:    scan_data = bit_cnt[1];
      PH_SHIFT_IN: scan_data = word_bit;
      default:     scan_data = 1'b0;
    endcase
  end
endmodule

// File: rtl/partial_scan_seq_chk.sv
module partial_scan_seq_chk #(
  parameter int N_SFF = 4,
  parameter int N_VEC = 3,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             tc,
  input logic             scan_clk_en,
  input logic             func_clk_en,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] clk_count
);
  localparam int TOTAL = (N_VEC + 2) * N_SFF + N_VEC + 4;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tc && !scan_clk_en && !func_clk_en));

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && clk_count == '0));

  assert_capture_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tc) |-> (scan_clk_en && func_clk_en));

  assert_single_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    func_clk_en |=> tc);

  assert_shift_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (scan_clk_en && !func_clk_en));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (clk_count == $past(clk_count) + CNT_W'(1)));

  assert_done_total_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_count == CNT_W'(TOTAL) && !busy));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(clk_count)));
endmodule

bind partial_scan_seq partial_scan_seq_chk #(
  .N_SFF(N_SFF), .N_VEC(N_VEC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tc(tc),
  .scan_clk_en(scan_clk_en), .func_clk_en(func_clk_en),
  .busy(busy), .done(done), .clk_count(clk_count)
);

// File: tb/partial_scan_seq_bench.sv
module partial_scan_seq_bench;
  localparam int N_SFF = 4;
  localparam int N_VEC = 3;
  localparam int PI_W  = 4;
  localparam int TOTAL = (N_VEC + 2) * N_SFF + N_VEC + 4;  // 27
  localparam int CNT_W = 5;

  // Stored vectors as stated in R10
  localparam logic [3:0] EXP_SCAN [3] = '{4'hC, 4'h5, 4'hA};
  localparam logic [3:0] EXP_PI   [3] = '{4'h6, 4'h9, 4'h3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tc, scan_clk_en, func_clk_en, scan_data, busy, done;
  logic [PI_W-1:0]  pi_vec;
  logic [CNT_W-1:0] clk_count;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  partial_scan_seq u_partial_scan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tc(tc),
    .scan_clk_en(scan_clk_en), .func_clk_en(func_clk_en),
    .scan_data(scan_data), .pi_vec(pi_vec), .busy(busy), .done(done),
    .clk_count(clk_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected {tc, scan_en, func_en, data, pi[3:0]} for session clock c
  function automatic logic [7:0] exp_row(input int c);
    int r, v, p;
    if (c < N_SFF + 4) return {3'b110, 1'((c >> 1) & 1), 4'h0};       // R3
    r = c - (N_SFF + 4);
    if (r < N_VEC * (N_SFF + 1)) begin
      v = r / (N_SFF + 1);
      p = r % (N_SFF + 1);
      if (p < N_SFF) return {3'b110, EXP_SCAN[v][N_SFF-1-p], 4'h0};    // R4
      return {3'b011, 1'b0, EXP_PI[v]};                                // R5
    end
    return {3'b110, 1'b0, 4'h0};                                       // R7
  endfunction

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 enables", {tc, scan_clk_en, func_clk_en}, 0);
    chk("R1 data", {scan_data, pi_vec}, 0);
    chk("R1 count", clk_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", busy, 0);
  endtask

  task automatic run_session(input string tag, input bit poke_start);
    logic [7:0] e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < TOTAL; c++) begin
      e = exp_row(c);
      chk({tag, " R2 busy"}, busy, 1);
      chk({tag, " R6 tc"}, tc, e[7]);
      chk({tag, " R6 scan_en"}, scan_clk_en, e[6]);
      chk({tag, " R5 func_en"}, func_clk_en, e[5]);
      chk({tag, " R3 R4 R7 scan_data"}, scan_data, e[4]);
      chk({tag, " R5 R10 pi_vec"}, pi_vec, e[3:0]);
      chk({tag, " R8 count"}, clk_count, c);
      if (poke_start && c == 10) start = 1'b1;   // R2: ignored while busy
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk({tag, " R8 done"}, done, 1);
    chk({tag, " R8 not busy"}, busy, 0);
    chk({tag, " R8 total"}, clk_count, TOTAL);
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk("R8 done held", done, 1);
    chk("R8 count held", clk_count, TOTAL);
    chk("R5 pi idle zero", pi_vec, 0);
  endtask

  initial begin
    t_reset();
    run_session("first", 1'b0);
    t_hold();
    run_session("R9 restart with R2 poke", 1'b1);
    t_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule